// File: doc/BRIEF.md
# Single-Bit Condition Flag Bank with Decode-Stage Branch Resolution

This block keeps sixteen separately addressable one-bit condition flags next to the decode stage of a small in-order pipeline. Compare and set-flag instructions write a single flag by index. The ALU refreshes its condition codes as well, and these live in the same index space as the general flags. A conditional branch names one flag index and a polarity. No test instruction is needed before the branch.

When a branch request reaches decode, the block reads the named flag and forwards any write that lands in the same cycle. One cycle later it reports the branch either as a no-op or as an unconditional jump to the target that came with the request. Decode can also say that an instruction writing a flag has left decode but not yet delivered its value. In that case a branch on that flag is not resolved. The block raises a stall instead, and decode keeps presenting the branch until the write arrives.

Top module: `flagbr_top`

## Requirements
- R1: Reset is a synchronous active-low input. While it is low, every flag is cleared to 0, every pending mark is cleared, and res_vld and br_stall are 0 from the next clock edge.
- R2: When fw_vld is high, the flag at index fw_idx takes the value fw_val at the clock edge. No other general flag (index 5 to 15) changes.
- R3: When alu_vld is high, flags 0 to 4 take alu_cc bits 0 to 4 in that order: zero, negative, positive, carry, overflow. Flags 5 to 15 are not affected.
- R4: A resolved branch is a jump exactly when the chosen flag equals br_pol. For a jump, res_jump is 1 and res_target equals the request's br_target. For a no-op, res_jump is 0 and res_target is 0.
- R5: res_vld is 1 in the cycle after a branch request that is not stalled, and 0 in every other cycle.
- R6: A flag write or ALU update in the same cycle as a branch request on that index is forwarded, so the branch resolves on the new value.
- R7: If fw_vld and alu_vld both target an index from 0 to 4 in one cycle, the fw_val write wins.
- R8: A pend_fw_vld mark on an index, or a pend_alu_vld mark on indices 0 to 4, makes any later branch on a marked index produce br_stall=1 with res_vld=0 in the next cycle. Branches on unmarked indices still resolve.
- R9: A mark clears when the matching write arrives: an fw write to that index, or an ALU update for indices 0 to 4. A branch in that same cycle resolves without a stall. If a mark is set and cleared on one index in the same cycle, the new mark is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_vld | input | 1 | Explicit flag write valid |
| fw_idx | input | 4 | Index of the flag to write |
| fw_val | input | 1 | Value to write |
| alu_vld | input | 1 | ALU condition update valid |
| alu_cc | input | 5 | Condition codes: bit0 zero, bit1 negative, bit2 positive, bit3 carry, bit4 overflow |
| pend_fw_vld | input | 1 | A flag-writing instruction has left decode |
| pend_fw_idx | input | 4 | Flag index that instruction will write |
| pend_alu_vld | input | 1 | A condition-updating ALU instruction has left decode |
| br_vld | input | 1 | Branch request in decode |
| br_idx | input | 4 | Flag index the branch tests |
| br_pol | input | 1 | Flag value that makes the branch taken |
| br_target | input | 32 | Branch target address |
| res_vld | output | 1 | Resolution valid |
| res_jump | output | 1 | 1 means jump, 0 means no-op |
| res_target | output | 32 | Jump target, 0 for a no-op |
| br_stall | output | 1 | The previous branch request must be held and retried |

## Verification
A flag bit stored with the wrong value, or left unchanged when it should have been written, shows only when a branch names that index. The result then appears with the wrong jump/no-op kind one cycle after the request. The stimulus therefore branches on each written index soon after the write, and also in the same cycle as the write. A stuck or missing pending mark shows at the port one cycle after the next branch on that index: either a stall that should not occur, or a resolution that should have been a stall. The sequences set a mark, retire it, and branch on neighbouring indices to expose both cases.

// File: rtl/flagbr_pkg.sv
// Package: shared constants for the flag bank and branch resolver.
// Assumes the ALU condition codes occupy the lowest flag indices.
package flagbr_pkg;
    localparam int CC_CNT  = 5;   // number of ALU condition codes
    localparam int CC_ZERO = 0;
    localparam int CC_NEG  = 1;
    localparam int CC_POS  = 2;
    localparam int CC_CRY  = 3;
    localparam int CC_OVF  = 4;
endpackage

// File: rtl/flag_bank.sv
// Module: flag_bank
// Holds FLAG_CNT one-bit flags. The lowest CC_CNT flags also take ALU
// condition updates. An explicit write has priority over an ALU update on
// the same index. flags_nx is the value each flag takes at the next edge.
// The resolver uses it as the forwarded read.
// Assumes FLAG_CNT >= CC_CNT.
module flag_bank
    import flagbr_pkg::*;
#(
    parameter int FLAG_CNT = 16,
    localparam int IDX_W   = $clog2(FLAG_CNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fw_vld,
    input  logic [IDX_W-1:0]     fw_idx,
    input  logic                 fw_val,
    input  logic                 alu_vld,
    input  logic [CC_CNT-1:0]    alu_cc,
    output logic [FLAG_CNT-1:0]  flags_q,
    output logic [FLAG_CNT-1:0]  flags_nx
);

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
        logic hit_fw;
        assign hit_fw = fw_vld && (fw_idx == IDX_W'(g));

        if (g < CC_CNT) begin : g_cc
            // Next value of a condition flag: explicit write, else ALU, else hold.
            always_comb begin
                if (hit_fw)       flags_nx[g] = fw_val;
                else if (alu_vld) flags_nx[g] = alu_cc[g];
                else              flags_nx[g] = flags_q[g];
            end
        end else begin : g_gp
            // Next value of a general flag: explicit write, else hold.
            always_comb begin
                if (hit_fw) flags_nx[g] = fw_val;
                else        flags_nx[g] = flags_q[g];
            end
        end

        // Flag storage with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[g] <= 1'b0;
            else        flags_q[g] <= flags_nx[g];
        end
    end

endmodule

// File: rtl/flag_scoreboard.sv
// Module: flag_scoreboard
// Keeps one pending mark per flag for writers that have left decode but
// have not delivered their value. An explicit-write mark names one index.
// An ALU mark covers all condition flags. A mark clears when the matching
// write arrives. A mark set in the same cycle as a clear is kept.
// blocked shows the flags a branch must not read this cycle.
// Assumes at most one writer in flight per flag.
module flag_scoreboard
    import flagbr_pkg::*;
#(
    parameter int FLAG_CNT = 16,
    localparam int IDX_W   = $clog2(FLAG_CNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pend_fw_vld,
    input  logic [IDX_W-1:0]     pend_fw_idx,
    input  logic                 pend_alu_vld,
    input  logic                 fw_vld,
    input  logic [IDX_W-1:0]     fw_idx,
    input  logic                 alu_vld,
    output logic [FLAG_CNT-1:0]  blocked
);

    logic [FLAG_CNT-1:0] pend_q;
    logic [FLAG_CNT-1:0] mark_set;
    logic [FLAG_CNT-1:0] mark_clr;

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_mark
        localparam bit IS_CC = (g < CC_CNT);

        // New in-flight writer for this flag.
        assign mark_set[g] = (pend_fw_vld && (pend_fw_idx == IDX_W'(g)))
                           || (IS_CC && pend_alu_vld);

        // Writer for this flag completes this cycle.
        assign mark_clr[g] = (fw_vld && (fw_idx == IDX_W'(g)))
                           || (IS_CC && alu_vld);

        // Pending mark register: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)           pend_q[g] <= 1'b0;
            else if (mark_set[g]) pend_q[g] <= 1'b1;
            else if (mark_clr[g]) pend_q[g] <= 1'b0;
        end

        // Blocked unless the value arrives now and can be forwarded.
        assign blocked[g] = pend_q[g] && !mark_clr[g];
    end

endmodule

// File: rtl/branch_resolve.sv
// Module: branch_resolve
// Turns a decode-stage branch request into a registered no-op or jump one
// cycle later, or into a registered stall if the named flag is blocked.
// Assumes flags_nx already includes any write in the request cycle.
module branch_resolve #(
    parameter int FLAG_CNT = 16,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = $clog2(FLAG_CNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 br_vld,
    input  logic [IDX_W-1:0]     br_idx,
    input  logic                 br_pol,
    input  logic [ADDR_W-1:0]    br_target,
    input  logic [FLAG_CNT-1:0]  flags_nx,
    input  logic [FLAG_CNT-1:0]  blocked,
    output logic                 res_vld,
    output logic                 res_jump,
    output logic [ADDR_W-1:0]    res_target,
    output logic                 br_stall
);

    logic sel_flag;
    logic sel_block;
    logic taken;

    // Read the named flag and its block state.
    always_comb begin
        sel_flag  = flags_nx[br_idx];
        sel_block = blocked[br_idx];
        taken     = (sel_flag == br_pol);
    end

    // Register the resolution or the stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld    <= 1'b0;
            res_jump   <= 1'b0;
            res_target <= '0;
            br_stall   <= 1'b0;
        end else begin
            res_vld    <= br_vld && !sel_block;
            res_jump   <= br_vld && !sel_block && taken;
            res_target <= (br_vld && !sel_block && taken) ? br_target : '0;
            br_stall   <= br_vld && sel_block;
        end
    end

endmodule

// File: rtl/flagbr_top.sv
// Module: flagbr_top
// Addressable one-bit flag bank with decode-stage branch resolution.
// Connects the flag storage, the in-flight writer scoreboard and the
// resolver. Assumes decode holds a stalled branch and presents it again.
module flagbr_top
    import flagbr_pkg::*;
#(
    parameter int FLAG_CNT = 16,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = $clog2(FLAG_CNT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fw_vld,
    input  logic [IDX_W-1:0]   fw_idx,
    input  logic               fw_val,
    input  logic               alu_vld,
    input  logic [CC_CNT-1:0]  alu_cc,
    input  logic               pend_fw_vld,
    input  logic [IDX_W-1:0]   pend_fw_idx,
    input  logic               pend_alu_vld,
    input  logic               br_vld,
    input  logic [IDX_W-1:0]   br_idx,
    input  logic               br_pol,
    input  logic [ADDR_W-1:0]  br_target,
    output logic               res_vld,
    output logic               res_jump,
    output logic [ADDR_W-1:0]  res_target,
    output logic               br_stall
);

    logic [FLAG_CNT-1:0] flags_q;
    logic [FLAG_CNT-1:0] flags_nx;
    logic [FLAG_CNT-1:0] blocked;

    flag_bank #(.FLAG_CNT(FLAG_CNT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .fw_vld   (fw_vld),
        .fw_idx   (fw_idx),
        .fw_val   (fw_val),
        .alu_vld  (alu_vld),
        .alu_cc   (alu_cc),
        .flags_q  (flags_q),
        .flags_nx (flags_nx)
    );

    flag_scoreboard #(.FLAG_CNT(FLAG_CNT)) u_sb (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_fw_vld  (pend_fw_vld),
        .pend_fw_idx  (pend_fw_idx),
        .pend_alu_vld (pend_alu_vld),
        .fw_vld       (fw_vld),
        .fw_idx       (fw_idx),
        .alu_vld      (alu_vld),
        .blocked      (blocked)
    );

    branch_resolve #(.FLAG_CNT(FLAG_CNT), .ADDR_W(ADDR_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_vld     (br_vld),
        .br_idx     (br_idx),
        .br_pol     (br_pol),
        .br_target  (br_target),
        .flags_nx   (flags_nx),
        .blocked    (blocked),
        .res_vld    (res_vld),
        .res_jump   (res_jump),
        .res_target (res_target),
        .br_stall   (br_stall)
    );

endmodule

// File: rtl/flagbr_checker.sv
// Module: flagbr_checker
// Property checks on the flag bank and resolver ports, bound to flagbr_top.
module flagbr_checker
    import flagbr_pkg::*;
#(
    parameter int FLAG_CNT = 16,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = $clog2(FLAG_CNT)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fw_vld,
    input logic [IDX_W-1:0]   fw_idx,
    input logic               fw_val,
    input logic               alu_vld,
    input logic [CC_CNT-1:0]  alu_cc,
    input logic               br_vld,
    input logic [ADDR_W-1:0]  br_target,
    input logic               res_vld,
    input logic               res_jump,
    input logic [ADDR_W-1:0]  res_target,
    input logic               br_stall,
    input logic [FLAG_CNT-1:0] flags_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && !br_stall && flags_q == '0));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fw_vld |=> flags_q[$past(fw_idx)] == $past(fw_val));

    p_alu_spares_gp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_vld && !fw_vld) |=>
        flags_q[FLAG_CNT-1:CC_CNT] == $past(flags_q[FLAG_CNT-1:CC_CNT]));

    p_alu_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_vld && !(fw_vld && fw_idx == IDX_W'(CC_ZERO))) |=>
        flags_q[CC_ZERO] == $past(alu_cc[CC_ZERO]));

    p_jump_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_jump) |-> res_target == $past(br_target));

    p_valid_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(br_vld));

    p_explicit_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_vld && alu_vld && int'(fw_idx) < CC_CNT) |=>
        flags_q[$past(fw_idx)] == $past(fw_val));

    p_stall_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_vld && br_stall));

    p_stall_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_stall |-> $past(br_vld));

endmodule

bind flagbr_top flagbr_checker #(.FLAG_CNT(FLAG_CNT), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fw_vld     (fw_vld),
    .fw_idx     (fw_idx),
    .fw_val     (fw_val),
    .alu_vld    (alu_vld),
    .alu_cc     (alu_cc),
    .br_vld     (br_vld),
    .br_target  (br_target),
    .res_vld    (res_vld),
    .res_jump   (res_jump),
    .res_target (res_target),
    .br_stall   (br_stall),
    .flags_q    (flags_q)
);

// File: tb/tb_flagbr_top.sv
module tb_flagbr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fw_vld = 1'b0;
    logic [3:0]  fw_idx = '0;
    logic        fw_val = 1'b0;
    logic        alu_vld = 1'b0;
    logic [4:0]  alu_cc = '0;
    logic        pend_fw_vld = 1'b0;
    logic [3:0]  pend_fw_idx = '0;
    logic        pend_alu_vld = 1'b0;
    logic        br_vld = 1'b0;
    logic [3:0]  br_idx = '0;
    logic        br_pol = 1'b0;
    logic [31:0] br_target = '0;
    logic        res_vld;
    logic        res_jump;
    logic [31:0] res_target;
    logic        br_stall;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    flagbr_top dut (
        .clk(clk), .rst_n(rst_n),
        .fw_vld(fw_vld), .fw_idx(fw_idx), .fw_val(fw_val),
        .alu_vld(alu_vld), .alu_cc(alu_cc),
        .pend_fw_vld(pend_fw_vld), .pend_fw_idx(pend_fw_idx),
        .pend_alu_vld(pend_alu_vld),
        .br_vld(br_vld), .br_idx(br_idx), .br_pol(br_pol),
        .br_target(br_target),
        .res_vld(res_vld), .res_jump(res_jump),
        .res_target(res_target), .br_stall(br_stall)
    );

    // Vector: {fw_vld, fw_idx, fw_val, alu_vld, alu_cc, br_vld, br_idx, br_pol, exp_vld, exp_jump}
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1,4'd7,1'b1, 1'b0,5'b00000, 1'b1,4'd7,1'b1, 1'b1,1'b1}, // R6 write forwarded
        {1'b0,4'd0,1'b0, 1'b0,5'b00000, 1'b1,4'd7,1'b0, 1'b1,1'b0}, // R4 polarity 0, flag 1
        {1'b0,4'd0,1'b0, 1'b1,5'b01010, 1'b1,4'd3,1'b1, 1'b1,1'b1}, // R3 R6 carry forwarded
        {1'b0,4'd0,1'b0, 1'b0,5'b00000, 1'b1,4'd0,1'b0, 1'b1,1'b1}, // R3 zero stays 0
        {1'b1,4'd1,1'b0, 1'b1,5'b11111, 1'b1,4'd1,1'b1, 1'b1,1'b0}, // R7 explicit wins
        {1'b0,4'd0,1'b0, 1'b0,5'b00000, 1'b1,4'd2,1'b1, 1'b1,1'b1}, // R3 positive from ALU
        {1'b0,4'd0,1'b0, 1'b0,5'b00000, 1'b1,4'd7,1'b1, 1'b1,1'b1}, // R3 general flag kept
        {1'b1,4'd7,1'b0, 1'b0,5'b00000, 1'b0,4'd0,1'b0, 1'b0,1'b0}, // R5 no request
        {1'b0,4'd0,1'b0, 1'b0,5'b00000, 1'b1,4'd7,1'b1, 1'b1,1'b0}, // R2 cleared flag
        {1'b0,4'd0,1'b0, 1'b0,5'b00000, 1'b1,4'd15,1'b0, 1'b1,1'b1}, // R2 top index
        {1'b0,4'd0,1'b0, 1'b1,5'b00000, 1'b1,4'd4,1'b0, 1'b1,1'b1}, // R6 overflow forwarded
        {1'b0,4'd0,1'b0, 1'b0,5'b00000, 1'b1,4'd3,1'b1, 1'b1,1'b0}  // R3 carry now 0
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        fw_vld = 0; alu_vld = 0; pend_fw_vld = 0; pend_alu_vld = 0; br_vld = 0;
        fw_idx = '0; fw_val = 0; alu_cc = '0; pend_fw_idx = '0;
        br_idx = '0; br_pol = 0; br_target = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic branch(input logic [3:0] idx, input logic pol, input logic [31:0] tgt);
        br_vld = 1; br_idx = idx; br_pol = pol; br_target = tgt;
    endtask

    // Check one resolution: valid, kind, target, stall.
    task automatic expect_res(input string req, input logic v, input logic j,
                              input logic [31:0] tgt, input logic st);
        check(req, {res_vld, res_jump, br_stall}, {v, j, st});
        check(req, res_target, (v && j) ? tgt : 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        idle();
        @(negedge clk);
        step(); step();
        // R1: outputs quiet under reset
        check("R1 reset outputs", {res_vld, br_stall}, 2'b00);
        rst_n = 1;
        // R1: flags cleared, so polarity 1 is a no-op
        branch(4'd5, 1'b1, 32'h0000_0AAA);
        step();
        expect_res("R1 flag cleared", 1'b1, 1'b0, 32'h0000_0AAA, 1'b0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            idle();
            fw_vld = v[19]; fw_idx = v[18:15]; fw_val = v[14];
            alu_vld = v[13]; alu_cc = v[12:8];
            br_vld = v[7]; br_idx = v[6:3]; br_pol = v[2];
            br_target = 32'h0000_1000 + 32'(i) * 16;
            step();
            expect_res($sformatf("R4 R5 vector %0d", i), v[1], v[0],
                       32'h0000_1000 + 32'(i) * 16, 1'b0);
        end

        // R8: explicit-write mark on flag 9
        idle(); pend_fw_vld = 1; pend_fw_idx = 4'd9;
        step();
        check("R5 idle no result", res_vld, 1'b0);
        idle(); branch(4'd9, 1'b1, 32'h2000);
        step();
        expect_res("R8 stall on marked flag", 1'b0, 1'b0, 32'h2000, 1'b1);
        idle(); branch(4'd8, 1'b0, 32'h2010);
        step();
        expect_res("R8 other flag resolves", 1'b1, 1'b1, 32'h2010, 1'b0);
        // R9: completing write clears the mark and is forwarded
        idle(); fw_vld = 1; fw_idx = 4'd9; fw_val = 1; branch(4'd9, 1'b1, 32'h2020);
        step();
        expect_res("R9 completing write resolves", 1'b1, 1'b1, 32'h2020, 1'b0);
        idle(); branch(4'd9, 1'b0, 32'h2030);
        step();
        expect_res("R9 mark gone", 1'b1, 1'b0, 32'h2030, 1'b0);

        // R8: ALU mark covers condition flags only
        idle(); pend_alu_vld = 1;
        step();
        idle(); branch(4'd2, 1'b1, 32'h3000);
        step();
        expect_res("R8 ALU mark stalls", 1'b0, 1'b0, 32'h3000, 1'b1);
        idle(); branch(4'd6, 1'b0, 32'h3010);
        step();
        expect_res("R8 ALU mark spares general", 1'b1, 1'b1, 32'h3010, 1'b0);
        idle(); alu_vld = 1; alu_cc = 5'b00100; branch(4'd2, 1'b1, 32'h3020);
        step();
        expect_res("R9 ALU update retires", 1'b1, 1'b1, 32'h3020, 1'b0);

        // R9: set and clear in one cycle keeps the mark
        idle(); pend_fw_vld = 1; pend_fw_idx = 4'd11; fw_vld = 1; fw_idx = 4'd11; fw_val = 1;
        step();
        idle(); branch(4'd11, 1'b1, 32'h4000);
        step();
        expect_res("R9 set wins over clear", 1'b0, 1'b0, 32'h4000, 1'b1);
        idle(); fw_vld = 1; fw_idx = 4'd11; fw_val = 0; branch(4'd11, 1'b1, 32'h4010);
        step();
        expect_res("R9 second write resolves", 1'b1, 1'b0, 32'h4010, 1'b0);

        // R1: reset in mid-run clears flags
        idle(); fw_vld = 1; fw_idx = 4'd10; fw_val = 1;
        step();
        idle(); rst_n = 0; branch(4'd10, 1'b1, 32'h5000);
        step();
        check("R1 mid-run reset outputs", {res_vld, br_stall}, 2'b00);
        rst_n = 1;
        step();
        expect_res("R1 flag cleared by reset", 1'b1, 1'b0, 32'h5000, 1'b0);

        idle();
        step();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule